// File: doc/BRIEF.md
# Pin Change Interrupt Generator

This block raises an interrupt request whenever a general-purpose pin that is set up as an input no longer matches the level held in a stored reference snapshot. The interrupt line is active low and open drain. The block models it as a pull-low enable: the output is 1 when the line should be pulled low and 0 when the line is released. The pins arrive already synchronised to the block clock. Each pin has a direction bit: 1 means input and 0 means output.

The reference snapshot is the value that software sees when it reads the input register. It is held inside the block and captures every pin, whatever its direction. It is loaded on the first clock after reset and reloaded on every read strobe. Two events clear the interrupt: every input pin returning to its stored level, or a read strobe. There is no status register and no mask register.

The comparison uses the raw pin levels; any polarity inversion applied to read data has no effect here. Both assertion and release of the output are registered, one clock after the cause.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is asserted, and on the first clock edge after reset is released, `irq_pull_o` is 0 (line released).
- R2: When any pin with its direction bit at 1 differs from the stored reference, `irq_pull_o` becomes 1 at the next rising clock edge.
- R3: When every input pin again matches the reference, `irq_pull_o` returns to 0 at the next rising clock edge.
- R4: A rising clock edge with `rd_strobe_i` = 1 makes `irq_pull_o` 0 after that edge, whatever the pins do in that cycle.
- R5: A pin whose direction bit is 0 never causes `irq_pull_o` to become 1, however its level changes.
- R6: A pin that changed level while it was an output raises `irq_pull_o` one clock after its direction bit is set to 1, provided no read occurred in between.
- R7: The reference is loaded with the pin levels on the first clock after reset. Pin levels present at reset therefore raise no interrupt, whatever their value.
- R8: With several input pins differing from the reference, `irq_pull_o` stays 1 until the last of them matches again.
- R9: A read strobe loads the reference with the pin levels sampled on that same edge. A pin held at its pre-read changed level raises nothing afterwards. Returning that pin to its old level raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | WIDTH | Synchronised pin levels, raw polarity |
| dir_in_i | input | WIDTH | Per-pin direction: 1 = input, 0 = output |
| rd_strobe_i | input | 1 | One-cycle strobe marking a read of the input register |
| irq_pull_o | output | 1 | 1 = pull the interrupt line low, 0 = release it |

## Verification
The bench starts from a non-zero pin pattern at reset. A design that loaded a fixed default into the reference would therefore interrupt straight out of reset. It toggles pins while they are outputs and then flips them to inputs, which catches a reference that tracks only input pins or an output mask left in place after the direction change. It clears two differing pins one at a time, so an OR-reduction built on the wrong bits would release the line early. It also changes a pin in the same cycle as a read, so a design that latched the reference one cycle late would leave a spurious interrupt behind.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;

    typedef struct packed {
        logic irq;
    } irq_state_t;

endpackage

// File: rtl/pin_change_ref.sv
module pin_change_ref #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    input  logic             rd_strobe_i,
    output logic [WIDTH-1:0] ref_o,
    output logic             primed_o
);
    typedef struct packed {
        logic             primed;
        logic [WIDTH-1:0] snap;
    } ref_state_t;

    ref_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.primed || rd_strobe_i) begin
            st_d.snap = pin_i;
        end
        st_d.primed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_o    = st_q.snap;
    assign primed_o = st_q.primed;

    // R9
    snap_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && st_q.primed) |=> (ref_o == $past(pin_i)));

    // R7
    snap_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.primed |=> (primed_o && ref_o == $past(pin_i)));

endmodule

// File: rtl/pin_change_diff.sv
module pin_change_diff #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] ref_i,
    input  logic [WIDTH-1:0] dir_in_i,
    output logic             any_diff_o
);
    logic [WIDTH-1:0] bit_diff;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        assign bit_diff[gi] = dir_in_i[gi] & (pin_i[gi] ^ ref_i[gi]);
    end

    assign any_diff_o = |bit_diff;

    // R5
    always_comb begin
        out_pins_quiet_chk: assert ((dir_in_i != '0) || !any_diff_o);
    end

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pin_change_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] dir_in_i,
    input  logic             rd_strobe_i,
    output logic             irq_pull_o
);
    logic [WIDTH-1:0] ref_w;
    logic             primed_w;
    logic             any_diff_w;

    irq_state_t st_d, st_q;

    pin_change_ref #(.WIDTH(WIDTH)) u_ref (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin_i),
        .rd_strobe_i (rd_strobe_i),
        .ref_o       (ref_w),
        .primed_o    (primed_w)
    );

    pin_change_diff #(.WIDTH(WIDTH)) u_diff (
        .pin_i      (pin_i),
        .ref_i      (ref_w),
        .dir_in_i   (dir_in_i),
        .any_diff_o (any_diff_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = primed_w && !rd_strobe_i && any_diff_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pull_o = st_q.irq;

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_w |=> !irq_pull_o);

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_i |=> !irq_pull_o);

    // R5
    outputs_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in_i == '0) |=> !irq_pull_o);

    // R2
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_w && !rd_strobe_i && ((pin_i ^ ref_w) & dir_in_i) != '0) |=> irq_pull_o);

    // R3
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_i ^ ref_w) & dir_in_i) == '0) |=> !irq_pull_o);

endmodule

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin = '0;
    logic [W-1:0] dir = '1;
    logic         rd = 1'b0;
    logic         irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pin_change_irq #(.WIDTH(W)) u_pin_change_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .dir_in_i    (dir),
        .rd_strobe_i (rd),
        .irq_pull_o  (irq)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: irq actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read();
        rd = 1'b1;
        step();
        rd = 1'b0;
    endtask

    task automatic t_reset();
        pin = 8'hA5; dir = '1; rst_n = 1'b0;
        step();
        chk("R1 in reset", irq, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 first edge", irq, 1'b0);
        step();
        chk("R7 nonzero pins at reset", irq, 1'b0);
    endtask

    task automatic t_change();
        pin = 8'hA4;
        step();
        chk("R2 raise", irq, 1'b1);
        pin = 8'hA5;
        step();
        chk("R3 release on return", irq, 1'b0);
    endtask

    task automatic t_read();
        pin = 8'hA4;
        step();
        chk("R2 raise before read", irq, 1'b1);
        do_read();
        chk("R4 read clears", irq, 1'b0);
        step();
        chk("R9 held level stays quiet", irq, 1'b0);
        pin = 8'hA5;
        step();
        chk("R9 old level raises", irq, 1'b1);
        do_read();
        chk("R4 second read clears", irq, 1'b0);
    endtask

    task automatic t_outputs();
        dir = 8'h0F;
        pin = 8'h55;
        step();
        chk("R5 output pins quiet", irq, 1'b0);
        pin = 8'hF5;
        step();
        chk("R5 output pins quiet again", irq, 1'b0);
        pin = 8'h55;
        step();
        dir = 8'hFF;
        step();
        chk("R6 direction flip raises", irq, 1'b1);
        do_read();
        chk("R4 read after flip", irq, 1'b0);
    endtask

    task automatic t_multi();
        pin = 8'h56;
        step();
        chk("R8 two pins raise", irq, 1'b1);
        pin = 8'h57;
        step();
        chk("R8 one pin still differs", irq, 1'b1);
        pin = 8'h55;
        step();
        chk("R8 all match release", irq, 1'b0);
    endtask

    task automatic t_read_same_cycle();
        pin = 8'h57;
        rd = 1'b1;
        step();
        rd = 1'b0;
        chk("R9 change with read", irq, 1'b0);
        step();
        chk("R9 change with read stays quiet", irq, 1'b0);
    endtask

    task automatic t_reset_mid();
        pin = 8'h56;
        step();
        chk("R2 raise before reset", irq, 1'b1);
        #2 rst_n = 1'b0;
        #1;
        chk("R1 async reset releases", irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        step();
        chk("R7 quiet after second reset", irq, 1'b0);
    endtask

    initial begin
        t_reset();
        t_change();
        t_read();
        t_outputs();
        t_multi();
        t_read_same_cycle();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule